// File: doc/BRIEF.md
# Single-Data-Phase Bus Initiator

This block is a bus master for a 32-bit multiplexed address/data bus of the PCI kind. Each transfer is either one memory read or one memory write, with exactly one data phase. A local request port supplies the address, the direction, the byte enables and the write data. The block then runs the bus sequence by itself: an address phase, the data phase with a turnaround for reads, a wait for the target to claim the cycle, the ready handshake, and the release of the bus.

The block drives the frame, initiator-ready, command/byte-enable and address/data lines. Each of them has its own output enable, so that pads outside the block can tri-state them. It samples the target's claim (devsel) and ready (trdy) lines. When the transfer ends, a one-cycle done pulse is returned, together with the captured read data. If no target claims the cycle, the done pulse comes with an error flag instead. Arbitration is outside the block, and the bus is assumed granted. Bus control lines are active low. The request's byte enables are active high.

Top module: `pci_sdp_master`

## Requirements
- R1: During and after reset the block is idle: `req_ready` is 1, `done` is 0, and all four output enables are 0.
- R2: In the cycle after `req_valid` is sampled high in idle, the address phase is driven for one cycle: `frame_n_o`=0, `irdy_n_o`=1, `ad_o`=request address, and `cbe_n_o`=4'b0110 for a read or 4'b0111 for a write, all with their enables high.
- R3: In the data phase `frame_n_o` is 1, `irdy_n_o` is 0, and `cbe_n_o` carries the bitwise inverse of the request's byte enables.
- R4: For a read, `ad_oe` is 0 from the first data-phase cycle on, which leaves the turnaround cycle to the target.
- R5: The data phase lasts, with no change on the outputs, for as long as `devsel_n_i` or `trdy_n_i` is sampled high, provided the claim limit of R9 has not expired.
- R6: For a read, on the first edge where `devsel_n_i` and `trdy_n_i` are both low, `ad_i` is captured. In the next cycle `done` is 1 for exactly one cycle, with that value on `rsp_rdata` and `rsp_err`=0.
- R7: For a write, the data phase drives `ad_oe`=1 with `ad_o` equal to the write data.
- R8: For a write, after the edge on which the target is ready, `irdy_n_o` goes to 1 while `ad_o`/`cbe_n_o` stay driven. This lasts until an edge samples `trdy_n_i` high. `done` follows in the next cycle with `rsp_err`=0.
- R9: If `devsel_n_i` is high on each of the first 5 data-phase edges, the transfer ends as a master abort: `done` and `rsp_err` are 1 in the cycle after the 5th edge. A claim seen on the 5th edge still counts.
- R10: In the done cycle `frame_n_o` and `irdy_n_o` are driven 1, while `ad_oe` and `cbe_oe` are 0. In the following cycle all enables are 0 and `req_ready` is 1.
- R11: `req_ready` is 1 only in idle. `req_valid` is ignored while busy or in the done cycle. Request fields are taken only at acceptance, so later changes to them do not reach the bus.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | Start request, sampled in idle |
| req_write | input | 1 | 1 for memory write, 0 for memory read |
| req_addr | input | 32 | Target byte address |
| req_be | input | 4 | Byte enables, active high |
| req_wdata | input | 32 | Write data |
| req_ready | output | 1 | Block idle, a request will be taken |
| done | output | 1 | One-cycle completion pulse |
| rsp_rdata | output | 32 | Captured read data, valid with done |
| rsp_err | output | 1 | Master abort flag, valid with done |
| frame_n_o | output | 1 | Frame line value |
| frame_oe | output | 1 | Frame line enable |
| irdy_n_o | output | 1 | Initiator-ready line value |
| irdy_oe | output | 1 | Initiator-ready line enable |
| cbe_n_o | output | 4 | Command / byte-enable value |
| cbe_oe | output | 1 | Command / byte-enable enable |
| ad_o | output | 32 | Address / data value |
| ad_oe | output | 1 | Address / data enable |
| ad_i | input | 32 | Address / data as seen on the bus |
| devsel_n_i | input | 1 | Target claim, active low |
| trdy_n_i | input | 1 | Target ready, active low |

## Verification
Each result is due at a fixed number of edges after its cause. The address phase appears one edge after acceptance, and the data phase one edge after that. Done, with its data or error, appears one edge after the ready edge for reads, or after the trdy-release edge for writes. An abort appears one edge after the fifth unclaimed data-phase edge. The bench drives inputs and samples outputs at the falling edge. From the target delays it chooses, it derives the expected phase for every falling edge and compares all outputs against it on every clock. The timing of claim and ready is varied: immediate, late, claim exactly on the last allowed edge, and no claim at all. A request left asserted through the done cycle shows that the bus stays idle.

// File: rtl/pci_sdp_master.sv
module pci_sdp_master #(
  parameter int DW          = 32,
  parameter int CLAIM_LIMIT = 5,
  parameter logic [3:0] CMD_RD = 4'b0110,
  parameter logic [3:0] CMD_WR = 4'b0111
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          req_valid,
  input  logic          req_write,
  input  logic [DW-1:0] req_addr,
  input  logic [DW/8-1:0] req_be,
  input  logic [DW-1:0] req_wdata,
  output logic          req_ready,
  output logic          done,
  output logic [DW-1:0] rsp_rdata,
  output logic          rsp_err,
  output logic          frame_n_o,
  output logic          frame_oe,
  output logic          irdy_n_o,
  output logic          irdy_oe,
  output logic [DW/8-1:0] cbe_n_o,
  output logic          cbe_oe,
  output logic [DW-1:0] ad_o,
  output logic          ad_oe,
  input  logic [DW-1:0] ad_i,
  input  logic          devsel_n_i,
  input  logic          trdy_n_i
);
  localparam int BW = DW / 8;
  localparam int CW = $clog2(CLAIM_LIMIT + 1);

  typedef enum logic [2:0] {S_IDLE, S_ADDR, S_DATA, S_HOLD, S_DONE} state_t;

  state_t        state;
  logic          lat_wr;
  logic [DW-1:0] lat_addr;
  logic [BW-1:0] lat_be;
  logic [DW-1:0] lat_wdata;
  logic [CW-1:0] wait_cnt;
  logic          claimed;

  wire hit      = !devsel_n_i && !trdy_n_i;
  wire give_up  = !claimed && devsel_n_i && (wait_cnt == CW'(CLAIM_LIMIT - 1));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state     <= S_IDLE;
      lat_wr    <= 1'b0;
      lat_addr  <= '0;
      lat_be    <= '0;
      lat_wdata <= '0;
      wait_cnt  <= '0;
      claimed   <= 1'b0;
      rsp_rdata <= '0;
      rsp_err   <= 1'b0;
    end else begin
      case (state)
        S_IDLE: if (req_valid) begin
          lat_wr    <= req_write;
          lat_addr  <= req_addr;
          lat_be    <= req_be;
          lat_wdata <= req_wdata;
          state     <= S_ADDR;
        end
        S_ADDR: begin
          wait_cnt <= '0;
          claimed  <= 1'b0;
          rsp_err  <= 1'b0;
          state    <= S_DATA;
        end
        S_DATA: begin
          if (!devsel_n_i) claimed <= 1'b1;
          if (hit) begin
            if (lat_wr) state <= S_HOLD;
            else begin
              rsp_rdata <= ad_i;
              state     <= S_DONE;
            end
          end else if (give_up) begin
            rsp_err <= 1'b1;
            state   <= S_DONE;
          end else if (!claimed) begin
            wait_cnt <= wait_cnt + 1'b1;
          end
        end
        S_HOLD: if (trdy_n_i) state <= S_DONE;
        S_DONE: state <= S_IDLE;
        default: state <= S_IDLE;
      endcase
    end
  end

  assign req_ready = (state == S_IDLE);
  assign done      = (state == S_DONE);
  assign frame_oe  = (state != S_IDLE);
  assign irdy_oe   = (state != S_IDLE);
  assign frame_n_o = (state != S_ADDR);
  assign irdy_n_o  = (state != S_DATA);
  assign cbe_oe    = (state == S_ADDR) || (state == S_DATA) || (state == S_HOLD);
  assign cbe_n_o   = (state == S_ADDR) ? (lat_wr ? CMD_WR : CMD_RD) : ~lat_be;
  assign ad_oe     = (state == S_ADDR) || (lat_wr && ((state == S_DATA) || (state == S_HOLD)));
  assign ad_o      = (state == S_ADDR) ? lat_addr : lat_wdata;
endmodule

// File: rtl/pci_sdp_master_chk.sv
module pci_sdp_master_chk #(
  parameter int DW = 32
) (
  input logic          clk,
  input logic          rst_n,
  input logic          req_ready,
  input logic          done,
  input logic          rsp_err,
  input logic          frame_n_o,
  input logic          frame_oe,
  input logic          irdy_n_o,
  input logic          irdy_oe,
  input logic [DW/8-1:0] cbe_n_o,
  input logic          cbe_oe,
  input logic          ad_oe,
  input logic          devsel_n_i,
  input logic          trdy_n_i
);
  AST_DONE_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done); // R6
  AST_IRDY_AFTER_FRAME: assert property (@(posedge clk) disable iff (!rst_n)
    (frame_oe && !frame_n_o) |=> (frame_n_o && !irdy_n_o)); // R3
  AST_READ_TURNAROUND: assert property (@(posedge clk) disable iff (!rst_n)
    (!frame_n_o && cbe_n_o == 4'b0110) |=> !ad_oe); // R4
  AST_BUSY_NOT_READY: assert property (@(posedge clk) disable iff (!rst_n)
    (frame_oe || irdy_oe) |-> !req_ready); // R11
  AST_DONE_RELEASE: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> (frame_n_o && irdy_n_o && !ad_oe && !cbe_oe)); // R10
  AST_DONE_THEN_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> (req_ready && !frame_oe && !irdy_oe)); // R10
  AST_ABORT_UNCLAIMED: assert property (@(posedge clk) disable iff (!rst_n)
    (done && rsp_err) |-> $past(devsel_n_i)); // R9
  AST_HOLD_TILL_RELEASE: assert property (@(posedge clk) disable iff (!rst_n)
    (ad_oe && irdy_oe && irdy_n_o && !frame_oe == 1'b0 && frame_n_o && !trdy_n_i) |=> ad_oe); // R8
endmodule

bind pci_sdp_master pci_sdp_master_chk #(.DW(DW)) chk (.*);

// File: tb/pci_sdp_master_test.sv
module pci_sdp_master_test;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        req_valid = 1'b0, req_write = 1'b0;
  logic [31:0] req_addr = '0, req_wdata = '0, ad_i = '0;
  logic [3:0]  req_be = '0;
  logic        devsel_n_i = 1'b1, trdy_n_i = 1'b1;
  logic        req_ready, done, rsp_err, frame_n_o, frame_oe, irdy_n_o, irdy_oe, cbe_oe, ad_oe;
  logic [31:0] rsp_rdata, ad_o;
  logic [3:0]  cbe_n_o;
  int checks = 0, errors = 0;

  always #4 clk = ~clk;

  pci_sdp_master uut (.*);

  task automatic chk(input string tag, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual=%h expected=%h", tag, act, exp);
    end
  endtask

  // bus snapshot: ready,done,frame_oe,frame_n,irdy_oe,irdy_n,cbe_oe,cbe,ad_oe ; ad masked by enable
  function automatic logic [63:0] pack(logic rd_, logic dn, logic fo, logic fn, logic io, logic in_,
                                        logic co, logic [3:0] cb, logic ao, logic [31:0] ad);
    return {19'd0, rd_, dn, fo, fn, io, in_, co, (co ? cb : 4'h0), ao, (ao ? ad : 32'h0)};
  endfunction

  function automatic logic [63:0] now_bus();
    return pack(req_ready, done, frame_oe, frame_n_o, irdy_oe, irdy_n_o, cbe_oe, cbe_n_o, ad_oe, ad_o);
  endfunction

  // kd < 0 : never claimed. kt: data-phase index of ready. h: write ready length.
  task automatic run(input logic wr, input logic [31:0] addr, input logic [3:0] be,
                     input logic [31:0] wd, input logic [31:0] rd, input int kd, input int kt,
                     input int h, input bit hold_req);
    bit abort = (kd < 0) || (kd >= 5);
    int last  = abort ? 4 : kt;
    int ht    = wr ? h : 1;
    int reln  = 3 + last + ((wr && !abort) ? h : 0);
    for (int n = 0; n <= reln; n++) begin
      @(negedge clk);
      if (n == 0)
        chk("R1 R11 idle", now_bus(), pack(1,0,0,1,0,1,0,0,0,0));
      else if (n == 1)
        chk("R2 address phase", now_bus(), pack(0,0,1,0,1,1,1, wr ? 4'b0111 : 4'b0110, 1, addr));
      else if (n <= 2 + last)
        chk(wr ? "R3 R5 R7 data phase" : "R3 R4 R5 data phase", now_bus(),
            pack(0,0,1,1,1,0,1,~be, wr, wd));
      else if (n < reln)
        chk("R8 write hold", now_bus(), pack(0,0,1,1,1,1,1,~be,1,wd));
      else begin
        chk("R10 done cycle", now_bus(), pack(0,1,1,1,1,1,0,0,0,0));
        chk(abort ? "R9 abort flag" : "R6 R8 error flag", {63'd0, rsp_err}, {63'd0, abort});
        if (!wr && !abort) chk("R6 read data", {32'd0, rsp_rdata}, {32'd0, rd});
      end
      // drive inputs for the next edge
      if (n == 0) begin
        req_valid = 1'b1; req_write = wr; req_addr = addr; req_be = be; req_wdata = wd;
      end else if (n == 1) begin
        req_valid = 1'b0; req_write = ~wr; req_addr = ~addr; req_be = ~be; req_wdata = ~wd;
      end else begin
        req_valid = (n == reln) && hold_req;
      end
      if (n >= 2 && n < reln) begin
        int j = n - 2;
        devsel_n_i = !(kd >= 0 && j >= kd && j < kt + ht);
        trdy_n_i   = !(!abort && j >= kt && j < kt + ht);
        ad_i       = (!wr && j == kt) ? rd : (32'hA5A5_0000 | j);
      end else begin
        devsel_n_i = 1'b1; trdy_n_i = 1'b1; ad_i = 32'hFFFF_FFFF;
      end
    end
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    errors++;
    $display("FAIL watchdog: actual=running expected=finished");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (2) @(negedge clk);
    chk("R1 reset state", now_bus(), pack(1,0,0,1,0,1,0,0,0,0));
    rst_n = 1'b1;
    run(0, 32'h1000_0040, 4'hF, 32'h0,         32'hCAFE_F00D, 0, 0, 1, 0); // R6 immediate read
    run(0, 32'h2000_0010, 4'h3, 32'h0,         32'h1234_5678, 1, 3, 1, 0); // R5 late ready
    run(0, 32'h3000_0000, 4'h8, 32'h0,         32'h8765_4321, 4, 6, 1, 0); // R9 claim on 5th edge
    run(0, 32'h4000_0004, 4'hF, 32'h0,         32'h0,        -1, 0, 1, 0); // R9 no claim
    run(1, 32'h5000_0008, 4'hF, 32'hDEAD_0001, 32'h0,         0, 0, 1, 0); // R7 R8 short
    run(1, 32'h6000_000C, 4'h5, 32'hBEEF_0002, 32'h0,         2, 2, 3, 1); // R8 long, R11 held req
    run(1, 32'h7000_0000, 4'hC, 32'h0BAD_0003, 32'h0,         0, 4, 2, 0); // R5 write wait
    run(1, 32'h7100_0000, 4'hF, 32'h1111_2222, 32'h0,        -1, 0, 1, 1); // R9 write abort, R11
    run(0, 32'h8000_0020, 4'h1, 32'h0,         32'h5A5A_A5A5, 0, 2, 1, 0); // R4 R6
    @(negedge clk);
    chk("R10 R11 final idle", now_bus(), pack(1,0,0,1,0,1,0,0,0,0));
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule